// File: doc/BRIEF.md
# Configuration Byte-Stream Loader

This block accepts a configuration image one byte per write strobe and feeds its payload to a configuration target, modelled as a plain byte sink. A restart strobe, raised when the host reads the restart location, puts the loader back to idle. The loader then expects one throw-away byte. After that come the 16 header bytes and the payload. Five zero pad bytes close the load. The payload length is read from the front of the header. The remaining header bytes are skipped without being examined.

The loader reports its result through two flags and a status byte. The done flag rises only once every pad byte has arrived cleanly. The error flag holds once set, until the next restart. The error flag is set by any of these: a bad pad byte, a byte written after done, or an end-of-stream strobe that arrives while the image is still incomplete. The host uses the error bit to decide whether the target is usable.

Top module: `cfg_stream_loader`

## Requirements
- R1: After reset or a restart strobe, done_o, err_o, sink_vld_o and status_o are all 0 and the loader waits for a new image.
- R2: The first byte written after reset or restart is a dummy: it is discarded and is neither part of the header nor sent to the sink.
- R3: The next 16 bytes form the header. Header bytes 0 to 3 give the payload length, with byte 0 the most significant. Header bytes 4 to 15 have no effect.
- R4: Every payload byte is presented on sink_byte_o with sink_vld_o high for exactly one cycle, the cycle after its write. Bytes appear in arrival order, and there are exactly as many strobes as the length field gives.
- R5: A header whose length field is zero leads straight to the pad phase, with no sink strobe.
- R6: After the payload, exactly five pad bytes of value 0x00 are required, and done_o rises after the fifth. A non-zero pad byte sets the error flag instead.
- R7: A byte written while done_o is high sets the error flag and clears done_o.
- R8: A close_i pulse during the header, payload or pad phase sets the error flag. The same pulse while idle or done has no effect.
- R9: The error flag holds until reset or restart. While it is set, written bytes produce no sink strobe.
- R10: status_o shows the error flag at bit 5 and the done flag at bit 0. All other bits are 0.
- R11: A restart strobe and a write in the same cycle act as a restart alone, and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Byte write strobe |
| wr_byte_i | input | 8 | Written byte |
| restart_rd_i | input | 1 | Read of the restart location; restarts the loader |
| close_i | input | 1 | End-of-stream strobe from the host |
| sink_vld_o | output | 1 | Payload byte valid towards the target |
| sink_byte_o | output | 8 | Payload byte towards the target |
| done_o | output | 1 | Image loaded completely and cleanly |
| err_o | output | 1 | Load failed (sticky) |
| status_o | output | 8 | Status byte: bit 5 error, bit 0 done |

## Verification
The bench builds the block with its default parameters: a 16-byte header, a 4-byte length field, five pad bytes and the registered sink output. With these values a 258-byte payload is within reach. That length has a non-zero value in two length bytes, so a reversed byte order would show up as a missing done flag. The bench also covers zero-length images, bad pad bytes at the middle and last positions, and closes during the payload. With the registered sink, each strobe can be checked against the write that produced it, one cycle later.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_PAY,
      ST_PAD,
      ST_DONE,
      ST_ERR
   } cbl_state_e;
endpackage

// File: rtl/cbl_hdr.sv
module cbl_hdr #(
   parameter int HDR_BYTES = 16,
   parameter int LEN_BYTES = 4,
   parameter int LEN_W     = 8 * LEN_BYTES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             take_i,
   input  logic [7:0]       byte_i,
   output logic             last_o,
   output logic [LEN_W-1:0] len_o
);
   localparam int CNT_W = $clog2(HDR_BYTES + 1);

   logic [CNT_W-1:0] hcnt_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] len_shift;
   logic             in_len;

   initial begin
      assert (LEN_BYTES >= 1 && LEN_BYTES < HDR_BYTES)
         else $error("length field must fit inside the header");
      assert (LEN_W == 8 * LEN_BYTES)
         else $error("length width must match the length bytes");
   end

   assign in_len    = hcnt_q < CNT_W'(LEN_BYTES);
   assign len_shift = LEN_W'({len_q, byte_i});
   assign last_o    = take_i && (hcnt_q == CNT_W'(HDR_BYTES - 1));
   assign len_o     = in_len ? len_shift : len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt_q <= '0;
         len_q  <= '0;
      end else if (clr_i) begin
         hcnt_q <= '0;
         len_q  <= '0;
      end else if (take_i) begin
         hcnt_q <= hcnt_q + 1'b1;
         if (in_len) len_q <= len_shift;
      end
   end
endmodule

// File: rtl/cbl_ctrl.sv
module cbl_ctrl
   import cbl_pkg::*;
#(
   parameter int LEN_W     = 32,
   parameter int PAD_BYTES = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             wr_i,
   input  logic [7:0]       byte_i,
   input  logic             close_i,
   input  logic             hdr_last_i,
   input  logic [LEN_W-1:0] hdr_len_i,
   output cbl_state_e       state_o,
   output logic             hdr_take_o,
   output logic             pay_take_o
);
   localparam int PW = $clog2(PAD_BYTES + 1);

   cbl_state_e       st_q, st_d;
   logic [LEN_W-1:0] rem_q, rem_d;
   logic [PW-1:0]    pcnt_q, pcnt_d;

   initial begin
      assert (PAD_BYTES >= 1) else $error("at least one pad byte required");
   end

   assign hdr_take_o = wr_i && !clr_i && (st_q == ST_HDR);
   assign pay_take_o = wr_i && !clr_i && (st_q == ST_PAY);
   assign state_o    = st_q;

   always_comb begin
      st_d   = st_q;
      rem_d  = rem_q;
      pcnt_d = pcnt_q;
      if (clr_i) begin
         st_d   = ST_IDLE;
         rem_d  = '0;
         pcnt_d = '0;
      end else begin
         if (wr_i) begin
            unique case (st_q)
               ST_IDLE: st_d = ST_HDR;
               ST_HDR: begin
                  if (hdr_last_i) begin
                     pcnt_d = '0;
                     rem_d  = hdr_len_i;
                     st_d   = (hdr_len_i == '0) ? ST_PAD : ST_PAY;
                  end
               end
               ST_PAY: begin
                  rem_d = rem_q - 1'b1;
                  if (rem_q == LEN_W'(1)) begin
                     st_d   = ST_PAD;
                     pcnt_d = '0;
                  end
               end
               ST_PAD: begin
                  if (byte_i != 8'h00)                    st_d = ST_ERR;
                  else if (pcnt_q == PW'(PAD_BYTES - 1))  st_d = ST_DONE;
                  else                                     pcnt_d = pcnt_q + 1'b1;
               end
               ST_DONE: st_d = ST_ERR;
               default: st_d = st_q;
            endcase
         end
         if (close_i && (st_d == ST_HDR || st_d == ST_PAY || st_d == ST_PAD))
            st_d = ST_ERR;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         rem_q  <= '0;
         pcnt_q <= '0;
      end else begin
         st_q   <= st_d;
         rem_q  <= rem_d;
         pcnt_q <= pcnt_d;
      end
   end

   // R9
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ERR && !clr_i) |=> (st_q == ST_ERR));
   // R1
   restart_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (st_q == ST_IDLE));
   // R6
   pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PAD && wr_i && byte_i != 8'h00 && !clr_i) |=> (st_q == ST_ERR));
   // R6
   done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_PAD && st_q != ST_DONE) |=> (st_q != ST_DONE));
   // R5
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_take_o && hdr_last_i && hdr_len_i == '0 && !close_i) |=> (st_q == ST_PAD));
   // R4
   pay_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pay_take_o |-> (rem_q != '0));
   // R7
   after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DONE && wr_i && !clr_i) |=> (st_q == ST_ERR));
endmodule

// File: rtl/cbl_sink.sv
module cbl_sink #(
   parameter bit REG_OUT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take_i,
   input  logic [7:0] byte_i,
   output logic       vld_o,
   output logic [7:0] byte_o
);
   generate
      if (REG_OUT) begin : g_reg
         logic       vld_q;
         logic [7:0] byte_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q  <= 1'b0;
               byte_q <= '0;
            end else begin
               vld_q <= take_i;
               if (take_i) byte_q <= byte_i;
            end
         end
         assign vld_o  = vld_q;
         assign byte_o = byte_q;

         // R4
         sink_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (vld_o && !take_i) |=> !vld_o);
      end else begin : g_comb
         assign vld_o  = take_i;
         assign byte_o = byte_i;
      end
   endgenerate
endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
   import cbl_pkg::*;
#(
   parameter int HDR_BYTES = 16,
   parameter int LEN_BYTES = 4,
   parameter int PAD_BYTES = 5,
   parameter bit SINK_REG  = 1'b1,
   parameter int ERR_BIT   = 5,
   parameter int DONE_BIT  = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en_i,
   input  logic [7:0] wr_byte_i,
   input  logic       restart_rd_i,
   input  logic       close_i,
   output logic       sink_vld_o,
   output logic [7:0] sink_byte_o,
   output logic       done_o,
   output logic       err_o,
   output logic [7:0] status_o
);
   localparam int LEN_W = 8 * LEN_BYTES;

   initial begin
      assert (ERR_BIT != DONE_BIT && ERR_BIT < 8 && DONE_BIT < 8)
         else $error("status bit positions must be distinct and inside a byte");
   end

   cbl_state_e       state;
   logic             hdr_take, pay_take, hdr_last;
   logic [LEN_W-1:0] hdr_len;

   cbl_hdr #(.HDR_BYTES(HDR_BYTES), .LEN_BYTES(LEN_BYTES), .LEN_W(LEN_W)) hdr_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (restart_rd_i),
      .take_i (hdr_take),
      .byte_i (wr_byte_i),
      .last_o (hdr_last),
      .len_o  (hdr_len)
   );

   cbl_ctrl #(.LEN_W(LEN_W), .PAD_BYTES(PAD_BYTES)) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (restart_rd_i),
      .wr_i       (wr_en_i),
      .byte_i     (wr_byte_i),
      .close_i    (close_i),
      .hdr_last_i (hdr_last),
      .hdr_len_i  (hdr_len),
      .state_o    (state),
      .hdr_take_o (hdr_take),
      .pay_take_o (pay_take)
   );

   cbl_sink #(.REG_OUT(SINK_REG)) sink_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .take_i (pay_take),
      .byte_i (wr_byte_i),
      .vld_o  (sink_vld_o),
      .byte_o (sink_byte_o)
   );

   assign done_o = (state == ST_DONE);
   assign err_o  = (state == ST_ERR);

   always_comb begin
      status_o           = '0;
      status_o[ERR_BIT]  = err_o;
      status_o[DONE_BIT] = done_o;
   end

   // R8
   idle_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && close_i && !wr_en_i && !restart_rd_i) |=> !err_o);
endmodule

// File: tb/cfg_stream_loader_tb.sv
`timescale 1ns/1ps
module cfg_stream_loader_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [7:0] wr_byte_i = '0;
   logic       restart_rd_i = 1'b0;
   logic       close_i = 1'b0;
   logic       sink_vld_o;
   logic [7:0] sink_byte_o;
   logic       done_o, err_o;
   logic [7:0] status_o;

   int n_run = 0;
   int n_fail = 0;
   int cur_row = 0;
   int scnt = 0;

   always #10 clk = ~clk;

   cfg_stream_loader dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_byte_i(wr_byte_i),
      .restart_rd_i(restart_rd_i), .close_i(close_i),
      .sink_vld_o(sink_vld_o), .sink_byte_o(sink_byte_o),
      .done_o(done_o), .err_o(err_o), .status_o(status_o)
   );

   // row: [47:32] length, [31:24] bad pad index (FF none),
   //      [23:16] close after N payload bytes (FF none), [8] extra byte after pads,
   //      [1] expected error, [0] expected done
   localparam logic [47:0] ROWS [0:7] = '{
      48'h0003_FF_FF_00_01,
      48'h0000_FF_FF_00_01,
      48'h0001_FF_FF_00_01,
      48'h0005_02_FF_00_02,
      48'h0004_FF_FF_01_02,
      48'h0006_FF_02_00_02,
      48'h0102_FF_FF_00_01,
      48'h0002_04_FF_00_02
   };

   function automatic logic [7:0] pat(int r, int i);
      return 8'(r * 16 + i * 3 + 1);
   endfunction

   task automatic chk(string req, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && sink_vld_o) begin
         chk("R4 sink byte order", int'(sink_byte_o), int'(pat(cur_row, scnt)));
         scnt++;
      end
   end

   task automatic wbyte(logic [7:0] b);
      @(negedge clk);
      wr_en_i = 1'b1;
      wr_byte_i = b;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic pulse_restart();
      @(negedge clk);
      restart_rd_i = 1'b1;
      @(negedge clk);
      restart_rd_i = 1'b0;
   endtask

   task automatic pulse_close();
      @(negedge clk);
      close_i = 1'b1;
      @(negedge clk);
      close_i = 1'b0;
   endtask

   task automatic run_row(int r, int len, int badpad, int stop, bit extra);
      bit stopped;
      stopped = 1'b0;
      pulse_restart();
      cur_row = r;
      scnt = 0;
      wbyte(8'hFF); // R2 dummy byte, would corrupt the length if kept
      for (int k = 0; k < 16; k++) begin
         if (k < 4) wbyte(8'(len >> (8 * (3 - k))));   // R3 MSB first
         else       wbyte(8'hA0 + 8'(k));              // R3 ignored bytes
      end
      for (int i = 0; i < len; i++) begin
         if (i == stop) begin
            stopped = 1'b1;
            break;
         end
         wbyte(pat(r, i));
      end
      if (stopped) begin
         pulse_close(); // R8
      end else begin
         for (int p = 0; p < 5; p++) wbyte((p == badpad) ? 8'h3C : 8'h00); // R6
         if (extra) wbyte(8'h00); // R7
      end
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", n_run, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 done after reset", int'(done_o), 0);
      chk("R1 err after reset", int'(err_o), 0);
      chk("R1 status after reset", int'(status_o), 0);
      chk("R1 sink after reset", int'(sink_vld_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int r = 0; r < 8; r++) begin
         logic [47:0] v;
         int len, badpad, stop, exp_cnt;
         v = ROWS[r];
         len = int'(v[47:32]);
         badpad = (v[31:24] == 8'hFF) ? -1 : int'(v[31:24]);
         stop = (v[23:16] == 8'hFF) ? -1 : int'(v[23:16]);
         exp_cnt = (stop >= 0) ? stop : len;
         run_row(r, len, badpad, stop, v[8]);
         chk("R6 done flag", int'(done_o), int'(v[0]));
         chk("R9 error flag", int'(err_o), int'(v[1]));
         chk("R10 status byte", int'(status_o), int'(v[1]) * 32 + int'(v[0]));
         chk("R4 R5 sink count", scnt, exp_cnt);
         if (r == 0) begin
            pulse_close();
            chk("R8 close while done", int'(done_o), 1);
            chk("R8 close while done err", int'(err_o), 0);
         end
         if (r == 5) begin
            for (int j = 0; j < 3; j++) wbyte(8'h11);
            repeat (2) @(negedge clk);
            chk("R9 no strobes in error", scnt, 2);
            chk("R9 error held", int'(err_o), 1);
         end
      end

      // R1 restart mid-load, then a full clean load
      pulse_restart();
      wbyte(8'hFF);
      wbyte(8'h00);
      wbyte(8'h07);
      run_row(9, 2, -1, -1, 1'b0);
      chk("R1 restart mid-load done", int'(done_o), 1);
      chk("R1 restart mid-load count", scnt, 2);

      // R11 restart and write in the same cycle while done
      @(negedge clk);
      restart_rd_i = 1'b1;
      wr_en_i = 1'b1;
      wr_byte_i = 8'h55;
      @(negedge clk);
      restart_rd_i = 1'b0;
      wr_en_i = 1'b0;
      @(negedge clk);
      chk("R11 restart wins err", int'(err_o), 0);
      chk("R11 restart wins status", int'(status_o), 0);

      // R8 close while idle has no effect
      pulse_close();
      chk("R8 close while idle", int'(err_o), 0);

      // R8 close during header
      wbyte(8'hFF);
      wbyte(8'h00);
      pulse_close();
      chk("R8 close during header", int'(err_o), 1);
      chk("R10 status error bit", int'(status_o), 32);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule